// File: doc/BRIEF.md
# DMA Channel Flag Register Block

This block keeps the per-channel control and status flags of a multi-channel DMA engine: which channels may accept hardware requests, which channels may raise an error interrupt, and which channels have a pending completion interrupt, a pending error or a done flag. Software never has to read, modify and write a whole vector to change one channel. It writes a channel number into one of eight byte-wide command registers, and the block sets or clears that one bit, or every bit when the "all channels" bit of the command byte is set.

The channel count is a parameter that takes the value 32 or 64. The two sizes use different register layouts. With 64 channels each vector is read as two 32-bit words, a high half and a low half, and the command bytes sit in a different order. Hardware event inputs set the pending bits. The block drives the flag vectors, a one-cycle start pulse per channel, a completion interrupt line and an error interrupt line.

Top module: `dma_chan_flag_regs`

## Requirements
- R1: After reset every flag vector, every start pulse and both interrupt lines are zero, and every readable word reads 0.
- R2: Writing index N (N below the channel count, command bits 7 and 6 clear) to the request-set byte sets only bit N of the request-enable vector. Writing it to the request-clear byte clears only bit N. No other write changes this vector.
- R3: The error-interrupt-enable vector is set and cleared one bit at a time in the same way through its own set and clear bytes.
- R4: A command byte with bit 6 set and bit 7 clear acts on every channel, whatever its low bits hold.
- R5: With bit 6 clear, an index in bits 5..0 that is at or above the channel count changes nothing.
- R6: Interrupt, error and done bits are set by their per-channel event inputs and cleared only by their clear command bytes. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: The interrupt line is high while any interrupt-pending bit is set. The error line is high while any error bit whose error-interrupt-enable bit is set is pending.
- R8: Writing an index to the start byte raises that channel's start output for exactly the one cycle after the write.
- R9: A command byte with bit 7 set does nothing, and byte writes to addresses that are not command bytes do nothing.
- R10: Readable words (byte address of the word): request-enable 0x0C, error-interrupt-enable 0x14, interrupt-pending 0x24, error-pending 0x2C. These hold channels 31..0. With 64 channels, channels 63..32 read at 0x08, 0x10, 0x20 and 0x28. All other words read 0.
- R11: With 32 channels the command bytes are: error-enable clear 0x18, error-enable set 0x19, request clear 0x1A, request set 0x1B, done clear 0x1C, start 0x1D, error clear 0x1E, interrupt clear 0x1F. With 64 channels they are: request set 0x18, request clear 0x19, error-enable set 0x1A, error-enable clear 0x1B, interrupt clear 0x1C, error clear 0x1D, start 0x1E, done clear 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address for writes, word select (bits 5..2) for reads |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write byte (command: bit 7 no-op, bit 6 all channels, bits 5..0 index) |
| bus_rdata | output | 32 | Read word at bus_addr, combinational |
| int_set_i | input | NCH | Per-channel completion event |
| err_set_i | input | NCH | Per-channel error event |
| done_set_i | input | NCH | Per-channel done event |
| req_en_o | output | NCH | Request-enable flags |
| err_ie_o | output | NCH | Error-interrupt-enable flags |
| int_pend_o | output | NCH | Interrupt-pending flags |
| err_pend_o | output | NCH | Error-pending flags |
| done_o | output | NCH | Done flags |
| start_o | output | NCH | One-cycle software start pulses |
| irq_o | output | 1 | Completion interrupt |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The bench runs a 32-channel and a 64-channel instance side by side, because a decoder that used one layout's offsets for the other would send a request-set byte to the error-enable vector or to the wrong clear. It writes the top index (31 and 63) and an index past 31 on the small instance, which catches an index that wraps into a low bit instead of being dropped. It drives an event and its clear into the same bit in the same cycle, where a design that gives the clear priority would lose a real interrupt. It also reads the high and low words of the 64-channel instance separately, which exposes swapped halves.

// File: rtl/dma_chan_flag_regs.sv
module dma_chan_flag_regs #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [5:0]     bus_addr,
  input  logic           bus_wr,
  input  logic [7:0]     bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] int_set_i,
  input  logic [NCH-1:0] err_set_i,
  input  logic [NCH-1:0] done_set_i,
  output logic [NCH-1:0] req_en_o,
  output logic [NCH-1:0] err_ie_o,
  output logic [NCH-1:0] int_pend_o,
  output logic [NCH-1:0] err_pend_o,
  output logic [NCH-1:0] done_o,
  output logic [NCH-1:0] start_o,
  output logic           irq_o,
  output logic           err_irq_o
);

  localparam bit WIDE = (NCH == 64);

  localparam logic [5:0] A_REQ_SET = WIDE ? 6'h18 : 6'h1B;
  localparam logic [5:0] A_REQ_CLR = WIDE ? 6'h19 : 6'h1A;
  localparam logic [5:0] A_EIE_SET = WIDE ? 6'h1A : 6'h19;
  localparam logic [5:0] A_EIE_CLR = WIDE ? 6'h1B : 6'h18;
  localparam logic [5:0] A_INT_CLR = WIDE ? 6'h1C : 6'h1F;
  localparam logic [5:0] A_ERR_CLR = WIDE ? 6'h1D : 6'h1E;
  localparam logic [5:0] A_START   = WIDE ? 6'h1E : 6'h1D;
  localparam logic [5:0] A_DON_CLR = WIDE ? 6'h1F : 6'h1C;

  localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

  logic [NCH-1:0] sel;
  logic           cmd_ok;

  assign cmd_ok = bus_wr && !bus_wdata[7];

  always_comb begin
    sel = '0;
    if (bus_wdata[6])
      sel = '1;
    else if (int'(bus_wdata[5:0]) < NCH)
      sel = ONE << bus_wdata[5:0];
  end

  function automatic logic [NCH-1:0] hit(input logic ok, input logic [5:0] a,
                                         input logic [5:0] target,
                                         input logic [NCH-1:0] m);
    return (ok && a == target) ? m : '0;
  endfunction

  logic [NCH-1:0] m_req_set, m_req_clr, m_eie_set, m_eie_clr;
  logic [NCH-1:0] m_int_clr, m_err_clr, m_don_clr, m_start;

  assign m_req_set = hit(cmd_ok, bus_addr, A_REQ_SET, sel);
  assign m_req_clr = hit(cmd_ok, bus_addr, A_REQ_CLR, sel);
  assign m_eie_set = hit(cmd_ok, bus_addr, A_EIE_SET, sel);
  assign m_eie_clr = hit(cmd_ok, bus_addr, A_EIE_CLR, sel);
  assign m_int_clr = hit(cmd_ok, bus_addr, A_INT_CLR, sel);
  assign m_err_clr = hit(cmd_ok, bus_addr, A_ERR_CLR, sel);
  assign m_don_clr = hit(cmd_ok, bus_addr, A_DON_CLR, sel);
  assign m_start   = hit(cmd_ok, bus_addr, A_START,   sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_en_o   <= '0;
      err_ie_o   <= '0;
      int_pend_o <= '0;
      err_pend_o <= '0;
      done_o     <= '0;
      start_o    <= '0;
    end else begin
      req_en_o   <= (req_en_o | m_req_set) & ~m_req_clr;
      err_ie_o   <= (err_ie_o | m_eie_set) & ~m_eie_clr;
      int_pend_o <= (int_pend_o & ~m_int_clr) | int_set_i;
      err_pend_o <= (err_pend_o & ~m_err_clr) | err_set_i;
      done_o     <= (done_o & ~m_don_clr) | done_set_i;
      start_o    <= m_start;
    end
  end

  assign irq_o     = |int_pend_o;
  assign err_irq_o = |(err_pend_o & err_ie_o);

  logic [31:0] req_hi, eie_hi, int_hi, err_hi;

  generate
    if (WIDE) begin : g_hi
      assign req_hi = req_en_o[NCH-1:32];
      assign eie_hi = err_ie_o[NCH-1:32];
      assign int_hi = int_pend_o[NCH-1:32];
      assign err_hi = err_pend_o[NCH-1:32];
    end else begin : g_no_hi
      assign req_hi = '0;
      assign eie_hi = '0;
      assign int_hi = '0;
      assign err_hi = '0;
    end
  endgenerate

  always_comb begin
    case (bus_addr[5:2])
      4'h2:    bus_rdata = req_hi;
      4'h3:    bus_rdata = req_en_o[31:0];
      4'h4:    bus_rdata = eie_hi;
      4'h5:    bus_rdata = err_ie_o[31:0];
      4'h8:    bus_rdata = int_hi;
      4'h9:    bus_rdata = int_pend_o[31:0];
      4'hA:    bus_rdata = err_hi;
      4'hB:    bus_rdata = err_pend_o[31:0];
      default: bus_rdata = '0;
    endcase
  end

endmodule

module dma_chan_flag_regs_chk #(
  parameter int NCH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [5:0]     bus_addr,
  input logic           bus_wr,
  input logic [NCH-1:0] int_set_i,
  input logic [NCH-1:0] req_en_o,
  input logic [NCH-1:0] int_pend_o,
  input logic [NCH-1:0] err_pend_o,
  input logic [NCH-1:0] start_o
);
  localparam bit WIDE = (NCH == 64);
  localparam logic [5:0] C_REQ_SET = WIDE ? 6'h18 : 6'h1B;
  localparam logic [5:0] C_REQ_CLR = WIDE ? 6'h19 : 6'h1A;
  localparam logic [5:0] C_INT_CLR = WIDE ? 6'h1C : 6'h1F;
  localparam logic [5:0] C_ERR_CLR = WIDE ? 6'h1D : 6'h1E;
  localparam logic [5:0] C_START   = WIDE ? 6'h1E : 6'h1D;

  AST_REQ_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en_o != $past(req_en_o)) |->
      $past(bus_wr && (bus_addr == C_REQ_SET || bus_addr == C_REQ_CLR))); // R2

  AST_INT_CLEARED_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ((~int_pend_o & $past(int_pend_o)) != '0) |->
      $past(bus_wr && bus_addr == C_INT_CLR)); // R6

  AST_ERR_CLEARED_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ((~err_pend_o & $past(err_pend_o)) != '0) |->
      $past(bus_wr && bus_addr == C_ERR_CLR)); // R6

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_set_i != '0) |=> ((int_pend_o & $past(int_set_i)) == $past(int_set_i))); // R6

  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |-> $past(bus_wr && bus_addr == C_START)); // R8
endmodule

bind dma_chan_flag_regs dma_chan_flag_regs_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .int_set_i(int_set_i), .req_en_o(req_en_o), .int_pend_o(int_pend_o),
  .err_pend_o(err_pend_o), .start_o(start_o)
);

// File: tb/tb_dma_chan_flag_regs.sv
module tb_dma_chan_flag_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr32 = 1'b0, wr64 = 1'b0;
  logic [31:0] rd32, rd64;
  logic [31:0] iset32 = '0, eset32 = '0, dset32 = '0;
  logic [63:0] iset64 = '0, eset64 = '0, dset64 = '0;
  logic [31:0] req32, eie32, int32, err32, don32, st32;
  logic [63:0] req64, eie64, int64, err64, don64, st64;
  logic irq32, eirq32, irq64, eirq64;

  dma_chan_flag_regs #(.NCH(32)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr32), .bus_wdata(wdata),
    .bus_rdata(rd32), .int_set_i(iset32), .err_set_i(eset32), .done_set_i(dset32),
    .req_en_o(req32), .err_ie_o(eie32), .int_pend_o(int32), .err_pend_o(err32),
    .done_o(don32), .start_o(st32), .irq_o(irq32), .err_irq_o(eirq32));

  dma_chan_flag_regs #(.NCH(64)) dut64 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr64), .bus_wdata(wdata),
    .bus_rdata(rd64), .int_set_i(iset64), .err_set_i(eset64), .done_set_i(dset64),
    .req_en_o(req64), .err_ie_o(eie64), .int_pend_o(int64), .err_pend_o(err64),
    .done_o(don64), .start_o(st64), .irq_o(irq64), .err_irq_o(eirq64));

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit big, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (big) wr64 = 1'b1; else wr32 = 1'b1;
    @(negedge clk);
    wr32 = 1'b0; wr64 = 1'b0;
  endtask

  task automatic rd(input bit big, input logic [5:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = big ? rd64 : rd32;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int w = 0; w < 16; w++) begin
      rd(0, 6'(w * 4), v); chk("R1 read32", v, 0);
      rd(1, 6'(w * 4), v); chk("R1 read64", v, 0);
    end
    chk("R1 flags32", {req32 | eie32 | int32 | err32 | don32 | st32, 30'b0, irq32, eirq32}, 0);
    chk("R1 flags64", req64 | eie64 | int64 | err64 | don64 | st64, 0);
    chk("R1 irq64", {irq64, eirq64}, 0);
  endtask

  task automatic t_request();
    logic [31:0] v;
    wr(0, 6'h1B, 8'd5);  rd(0, 6'h0C, v); chk("R2 set5", v, 32'h20);
    wr(0, 6'h1B, 8'd31); rd(0, 6'h0C, v); chk("R2 set31", v, 32'h8000_0020);
    wr(0, 6'h1A, 8'd5);  rd(0, 6'h0C, v); chk("R2 clr5", v, 32'h8000_0000);
    rd(0, 6'h14, v); chk("R11 req bytes leave eie32", v, 0);
    wr(1, 6'h18, 8'd40); rd(1, 6'h08, v); chk("R10 R11 hi set40", v, 32'h100);
    rd(1, 6'h0C, v); chk("R10 lo untouched", v, 0);
    wr(1, 6'h18, 8'd63); wr(1, 6'h19, 8'd40);
    chk("R2 R11 64 vector", req64, 64'h8000_0000_0000_0000);
    rd(1, 6'h10, v); chk("R11 req bytes leave eie64", v, 0);
  endtask

  task automatic t_err_enable();
    logic [31:0] v;
    wr(0, 6'h19, 8'd2); rd(0, 6'h14, v); chk("R3 set2", v, 32'h4);
    wr(0, 6'h18, 8'd2); rd(0, 6'h14, v); chk("R3 clr2", v, 0);
    wr(1, 6'h1A, 8'd33); rd(1, 6'h10, v); chk("R3 R10 hi", v, 32'h2);
    wr(1, 6'h1B, 8'd33); chk("R3 clr64", eie64, 0);
  endtask

  task automatic t_all_and_ignore();
    logic [31:0] v;
    wr(0, 6'h1A, 8'h40); chk("R4 clr all32", req32, 0);
    wr(0, 6'h1B, 8'h40); chk("R4 set all32", req32, 32'hFFFF_FFFF);
    wr(0, 6'h1A, 8'h47); chk("R4 clr all low bits", req32, 0);
    wr(1, 6'h18, 8'h40); rd(1, 6'h08, v); chk("R4 all64 hi", v, 32'hFFFF_FFFF);
    rd(1, 6'h0C, v); chk("R4 all64 lo", v, 32'hFFFF_FFFF);
    wr(1, 6'h19, 8'h7F); chk("R4 clr all64", req64, 0);
    wr(0, 6'h1B, 8'd40); chk("R5 index 40 ignored", req32, 0);
    wr(0, 6'h1B, 8'd32); chk("R5 index 32 ignored", req32, 0);
    wr(0, 6'h1B, 8'h83); chk("R9 bit7 no-op", req32, 0);
    wr(0, 6'h0C, 8'hFF); rd(0, 6'h0C, v); chk("R9 word write ignored", v, 0);
    wr(1, 6'h1B, 8'h40); chk("R9 R11 64 eie clr not req", req64, 0);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    @(negedge clk); iset32 = 32'h80; @(negedge clk); iset32 = '0;
    rd(0, 6'h24, v); chk("R6 int set", v, 32'h80);
    chk("R7 irq high", irq32, 1);
    wr(0, 6'h1E, 8'd7); chk("R6 err clr keeps int", int32, 32'h80);
    wr(0, 6'h1F, 8'd7); rd(0, 6'h24, v); chk("R6 int clr", v, 0);
    chk("R7 irq low", irq32, 0);
    @(negedge clk); iset32 = 32'h4; addr = 6'h1F; wdata = 8'd2; wr32 = 1'b1;
    @(negedge clk); iset32 = '0; wr32 = 1'b0;
    chk("R6 set wins", int32, 32'h4);
    wr(0, 6'h1F, 8'h40); chk("R6 R4 clr all int", int32, 0);
    @(negedge clk); eset32 = 32'h10; @(negedge clk); eset32 = '0;
    rd(0, 6'h2C, v); chk("R6 err set", v, 32'h10);
    chk("R7 err masked", eirq32, 0);
    wr(0, 6'h19, 8'd4); chk("R7 err enabled", eirq32, 1);
    wr(0, 6'h1E, 8'd4); chk("R7 err cleared", {err32, 31'b0, eirq32}, 0);
    @(negedge clk); iset64 = 64'h1 << 50; eset64 = 64'h1 << 3; @(negedge clk);
    iset64 = '0; eset64 = '0;
    rd(1, 6'h20, v); chk("R10 int hi", v, 32'h4_0000);
    rd(1, 6'h2C, v); chk("R10 err lo", v, 32'h8);
    wr(1, 6'h1F, 8'd50); chk("R11 64 done clr not int", int64, 64'h1 << 50);
    wr(1, 6'h1C, 8'd50); chk("R6 R11 int clr64", {63'b0, irq64}, 0);
    wr(1, 6'h1D, 8'd3); chk("R6 R11 err clr64", err64, 0);
  endtask

  task automatic t_start_done();
    @(negedge clk); addr = 6'h1D; wdata = 8'd9; wr32 = 1'b1;
    @(negedge clk); wr32 = 1'b0;
    chk("R8 start pulse", st32, 32'h200);
    @(negedge clk); chk("R8 start one cycle", st32, 0);
    @(negedge clk); addr = 6'h1E; wdata = 8'd63; wr64 = 1'b1;
    @(negedge clk); wr64 = 1'b0;
    chk("R8 R11 start64", st64, 64'h8000_0000_0000_0000);
    @(negedge clk); chk("R8 start64 one cycle", st64, 0);
    @(negedge clk); dset32 = 32'h2; dset64 = 64'h2; @(negedge clk); dset32 = '0; dset64 = '0;
    chk("R6 done set", don32, 32'h2);
    wr(0, 6'h1C, 8'd1); chk("R6 R11 done clr32", don32, 0);
    wr(1, 6'h1F, 8'd1); chk("R6 R11 done clr64", don64, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_request();
    t_err_enable();
    t_all_and_ignore();
    t_pending();
    t_start_done();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule